// File: doc/BRIEF.md
# Parallel-Prefix Four-State Automaton Evaluator

This block evaluates a four-state finite automaton over the alphabet {0, 1} on a whole string at once. It does not step the machine once per clock. The string of `N` symbols, the start state and two programmable transition tables are applied together. The block reports the state reached after every prefix of the string, with symbol 0 consumed first.

Each symbol is first mapped to the transition function it selects. Each function is a vector of four 2-bit next states. Functions are then merged in a logarithmic-depth prefix network, so that every prefix function is available. Each prefix function is finally indexed by the start state. Merging two functions takes a fixed amount of logic whatever `N` is, so the depth grows with log2(N) and not with N.

A parameter selects whether the results pass through an output register or leave the block combinationally.

Top module: `dfaPrefixEval`

## Requirements
- R1: `tableZero` is the transition function for symbol value 0 and `tableOne` the one for symbol value 1. In both tables, bits [2s+1:2s] hold the next state from current state s, and states are coded 0..3 in binary.
- R2: Entry 0 of the result is the table selected by `symbols[0]`, indexed by `startState`.
- R3: For every i > 0, entry i is the table selected by `symbols[i]`, indexed by entry i-1.
- R4: Entry i of the result occupies `prefixStates[2i+1:2i]`.
- R5: With `REG_OUT=1`, `prefixStates` is zero while `rstN` is low and remains zero after the first rising edge following release.
- R6: With `REG_OUT=1`, from the second edge after release onward, `prefixStates` after each rising edge shows the result for the inputs present at that edge.
- R7: When both tables are the identity, every entry equals `startState`, for any symbol string.
- R8: When both tables map every state to the same constant k, every entry equals k, whatever the start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| symbols | input | N | Symbol string; bit 0 is consumed first |
| startState | input | 2 | State before the first symbol |
| tableZero | input | 8 | Next-state table for symbol 0 |
| tableOne | input | 8 | Next-state table for symbol 1 |
| prefixStates | output | 2*N | State after each prefix, 2 bits per entry |

## Verification
A new start state and new tables can land in the same cycle as a new symbol string. Every entry then depends on all three at once, and an error in how the tables are merged cannot be told apart from an error in how the start state is applied. The bench changes all inputs together on every cycle, with random tables and strings and a sweep over all four start states. It judges each registered result against a model that walks the string one symbol at a time. The edge where the output register leaves its cleared state and captures its first result is also checked against that model.

// File: rtl/dfaPrefixPkg.sv
package dfaPrefixPkg;
  typedef logic [1:0] stateT;
  typedef logic [3:0][1:0] funcT;

  typedef struct packed {
    logic capture;
    logic clear;
  } ctrlStrobeT;

  // later applied after earlier: result[s] = later[earlier[s]]
  function automatic funcT composeFn(funcT later, funcT earlier);
    funcT res;
    for (int s = 0; s < 4; s++) res[s] = later[earlier[s]];
    return res;
  endfunction
endpackage

// File: rtl/dfaSymbolMap.sv
module dfaSymbolMap #(
  parameter int N = 8
) (
  input  logic [N-1:0]               symbols,
  input  dfaPrefixPkg::funcT         tableZero,
  input  dfaPrefixPkg::funcT         tableOne,
  output dfaPrefixPkg::funcT [N-1:0] leafFn
);
  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign leafFn[i] = symbols[i] ? tableOne : tableZero;
  end
endmodule

// File: rtl/dfaPrefixTree.sv
module dfaPrefixTree #(
  parameter int N = 8
) (
  input  dfaPrefixPkg::funcT [N-1:0] leafFn,
  output dfaPrefixPkg::funcT [N-1:0] prefixFn
);
  import dfaPrefixPkg::*;
  localparam int LEVELS = $clog2(N);

  funcT stage [LEVELS+1][N];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign stage[0][i] = leafFn[i];
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int DIST = 1 << lv;
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= DIST) begin : g_merge
        assign stage[lv+1][i] = composeFn(stage[lv][i], stage[lv][i-DIST]);
      end else begin : g_pass
        assign stage[lv+1][i] = stage[lv][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign prefixFn[i] = stage[LEVELS][i];
  end
endmodule

// File: rtl/dfaControl.sv
module dfaControl (
  input  logic                     clk,
  input  logic                     rstN,
  output dfaPrefixPkg::ctrlStrobeT strobe
);
  logic runReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runReg <= 1'b0;
    else       runReg <= 1'b1;
  end

  assign strobe.capture = runReg;
  assign strobe.clear   = !runReg;
endmodule

// File: rtl/dfaDatapath.sv
module dfaDatapath #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dfaPrefixPkg::ctrlStrobeT strobe,
  input  logic [N-1:0]             symbols,
  input  logic [1:0]               startState,
  input  logic [7:0]               tableZero,
  input  logic [7:0]               tableOne,
  output logic [2*N-1:0]           prefixStates
);
  import dfaPrefixPkg::*;

  funcT tabZ, tabO;
  funcT [N-1:0] leafFn;
  funcT [N-1:0] prefixFn;
  logic [2*N-1:0] combVec;

  assign tabZ = tableZero;
  assign tabO = tableOne;

  dfaSymbolMap #(.N(N)) u_map (
    .symbols (symbols),
    .tableZero(tabZ),
    .tableOne (tabO),
    .leafFn  (leafFn)
  );

  dfaPrefixTree #(.N(N)) u_tree (
    .leafFn  (leafFn),
    .prefixFn(prefixFn)
  );

  for (genvar i = 0; i < N; i++) begin : g_apply
    assign combVec[2*i +: 2] = prefixFn[i][startState];

    if (i == 0) begin : g_first
      a_r2_first_entry: assert property (@(posedge clk) disable iff (!rstN)
        combVec[1:0] == (symbols[0] ? tabO[startState] : tabZ[startState]));
    end else begin : g_chain
      a_r3_chain: assert property (@(posedge clk) disable iff (!rstN)
        combVec[2*i +: 2] == (symbols[i] ? tabO[combVec[2*i-2 +: 2]]
                                         : tabZ[combVec[2*i-2 +: 2]]));
    end
  end

  if (REG_OUT) begin : g_reg
    logic [2*N-1:0] outReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              outReg <= '0;
      else if (strobe.clear)  outReg <= '0;
      else if (strobe.capture) outReg <= combVec;
    end
    assign prefixStates = outReg;

    a_r5_cleared_after_release: assert property (@(posedge clk) disable iff (!rstN)
      !$past(rstN) |-> outReg == '0);
    a_r6_capture: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe.capture) |-> outReg == $past(combVec));
  end else begin : g_comb
    assign prefixStates = combVec;
  end
endmodule

// File: rtl/dfaPrefixEval.sv
module dfaPrefixEval #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   symbols,
  input  logic [1:0]     startState,
  input  logic [7:0]     tableZero,
  input  logic [7:0]     tableOne,
  output logic [2*N-1:0] prefixStates
);
  dfaPrefixPkg::ctrlStrobeT strobe;

  initial begin
    if (N < 2 || (N & (N - 1)) != 0)
      $error("N must be a power of two of at least 2");
  end

  dfaControl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  dfaDatapath #(.N(N), .REG_OUT(REG_OUT)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .symbols     (symbols),
    .startState  (startState),
    .tableZero   (tableZero),
    .tableOne    (tableOne),
    .prefixStates(prefixStates)
  );
endmodule

// File: tb/dfaPrefixEval_tb.sv
module dfaPrefixEval_tb;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   symbols = '0;
  logic [1:0]     startState = '0;
  logic [7:0]     tableZero = '0;
  logic [7:0]     tableOne = '0;
  logic [2*N-1:0] prefixStates;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dfaPrefixEval #(.N(N), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .symbols(symbols), .startState(startState),
    .tableZero(tableZero), .tableOne(tableOne), .prefixStates(prefixStates)
  );

  // step the machine one symbol at a time
  function automatic logic [2*N-1:0] refModel(logic [N-1:0] sym, logic [1:0] st0,
                                              logic [7:0] t0, logic [7:0] t1);
    logic [2*N-1:0] res = '0;
    int st = st0;
    for (int i = 0; i < N; i++) begin
      st = sym[i] ? int'(t1[2*st +: 2]) : int'(t0[2*st +: 2]);
      res[2*i +: 2] = st[1:0];
    end
    return res;
  endfunction

  task automatic check(string req, logic [2*N-1:0] expv);
    checks++;
    if (prefixStates !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, prefixStates, expv);
    end
  endtask

  // drive at negedge, let one posedge capture, sample at next negedge
  task automatic apply(logic [N-1:0] s, logic [1:0] st, logic [7:0] t0,
                       logic [7:0] t1, string req);
    symbols = s; startState = st; tableZero = t0; tableOne = t1;
    @(negedge clk);
    check(req, refModel(s, st, t0, t1));
  endtask

  initial begin
    logic [7:0] ident, cnst;
    ident = 8'b11_10_01_00;
    repeat (3) @(negedge clk);
    check("R5 during reset", '0);
    symbols = 8'hA5; tableZero = 8'h1B; tableOne = 8'hE4; startState = 2'd2;
    rstN = 1'b1;
    @(negedge clk);
    check("R5 first edge after release", '0);
    @(negedge clk);
    check("R6 first capture", refModel(8'hA5, 2'd2, 8'h1B, 8'hE4));

    // R1: all-ones string uses only tableOne; tableZero is garbage
    apply('1, 2'd0, 8'b00_00_00_00, 8'b00_11_10_01, "R1 table one only");
    apply('0, 2'd0, 8'b00_11_10_01, 8'b11_11_11_11, "R1 table zero only");
    // R2/R4: first entry sits in bits [1:0]
    apply(8'h01, 2'd3, 8'h00, 8'b01_10_11_00, "R2 R4 first entry");
    // R7: identity tables
    for (int st = 0; st < 4; st++)
      apply(8'h6C ^ 8'(st * 37), st[1:0], ident, ident, "R7 identity");
    // R8: constant tables
    for (int k = 0; k < 4; k++) begin
      cnst = {4{k[1:0]}};
      for (int st = 0; st < 4; st++)
        apply(8'h93 + 8'(k), st[1:0], cnst, cnst, "R8 constant");
    end
    // R3 R6: random tables, strings and every start state, all changed together
    for (int n = 0; n < 400; n++)
      apply(N'($urandom), 2'(n % 4), 8'($urandom), 8'($urandom), "R3 R6 random");
    // R3: alternating symbols with a swap function and a shift function
    apply(8'h55, 2'd1, 8'b01_00_11_10, 8'b00_11_10_01, "R3 alternating");
    apply(8'hAA, 2'd3, 8'b01_00_11_10, 8'b00_11_10_01, "R3 alternating");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule